// File: doc/BRIEF.md
# Watchdog Timer with Register Port

The block is a watchdog timer driven through a small synchronous register port. Software sets a reload value while the timer is stopped, and then starts the timer by writing a value other than the stop code into the enable field of the control register. While it runs, a live counter counts down by one on every clock. Software keeps the timer from expiring by writing anything to the status register, which reloads the live counter. If the counter reaches zero, the timer reloads itself and sets a sticky rollover flag. It also pulses one of three event pins (system reset, non-maskable interrupt or general interrupt), or none of them, depending on a 2-bit select field.

The port accepts one access per clock. An access is presented with a byte address, write and read strobes, a size code and write data. The read data and an access-error flag are registered and are valid in the cycle after the access. The register offsets are 0x0 for control (16 bits), 0x4 for reload (32 bits) and 0x8 for the live status counter (32 bits).

A three-state machine sequences the timer. ST_IDLE means the timer is stopped. ST_RUN means it is counting. ST_FIRE is the single cycle in which the event pin is driven. The transitions are:
- Any state goes to ST_IDLE whenever the enable field holds the stop code.
- While enabled, any state goes to ST_RUN on a service write or when the live count is not zero.
- While enabled, any state goes to ST_FIRE when the live count is zero and there is no service write.

Top module: `wdt_top`

## Requirements
- R1: After reset, control reads 0x0AD0, reload and status read 0, no event pin is high and bus_err is low.
- R2: Size code 01 (16-bit) and 10 (32-bit) are accepted. Codes 00 and 11 raise bus_err in the next cycle, return 0 and change nothing. This check applies ahead of the offset decode, so a bad-size access to an unmapped offset also raises bus_err.
- R3: A 32-bit read of control raises bus_err and returns 0. A 16-bit read of control returns the register zero-extended.
- R4: A read of an unmapped offset (0xC) returns 0 without error, and a write there changes nothing.
- R5: While stopped, a reload write stores the value and copies it into status. A 16-bit write replaces bits [15:0] and keeps bits [31:16].
- R6: While running, reload writes are discarded.
- R7: While running, any write to status sets the live count to the reload value, whatever the data. While stopped, status writes are ignored.
- R8: Control bits [11:4] hold the enable field. The value 0xAD stops the timer and any other value runs it. While running, the live count falls by one per clock.
- R9: When the live count is zero on a running clock edge, the count reloads and control bit 15 (rollover) is set. The event pulse is seen N+1 clocks after the edge that starts the timer with reload N.
- R10: Control bits [1:0] choose the event pin: 00 reset, 01 NMI, 10 general interrupt, 11 none. For a non-zero reload, the pulse lasts one clock and at most one pin is high.
- R11: Writing 1 to bit 15 clears the rollover flag and writing 0 keeps it. A set from an expiry wins over a clear in the same cycle. All other control bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 reserved |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| bus_err | output | 1 | Registered access-error flag |
| wd_reset | output | 1 | Expiry event, reset selection |
| wd_nmi | output | 1 | Expiry event, NMI selection |
| wd_gpi | output | 1 | Expiry event, general interrupt selection |

## Verification
The bench sweeps every size code against every offset. This catches a design that decodes the offset before checking the size, and one that allows a wide read of control. It sweeps all four event selections across several short reload values and counts the exact clock of each pulse, so an off-by-one expiry, a pulse on the wrong pin, or a pulse that lasts two cycles shows up as a mismatch. It also confirms that a reload write made while the timer runs leaves the stored value untouched. Finally, it checks that writing 0 to the rollover bit keeps the flag while writing 1 clears it, which exposes a plain-write or toggle implementation.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CTL_W     = 16;
    localparam int HALF_W    = 16;
    localparam int EN_LSB    = 4;
    localparam int EN_W      = 8;
    localparam int ROLL_BIT  = 15;
    localparam int SEL_W     = 2;
    localparam int NUM_EVT   = 3;
    localparam logic [EN_W-1:0]  EN_STOP   = 8'hAD;
    localparam logic [CTL_W-1:0] CTL_RESET = 16'h0AD0;

    localparam int OFF_CTL  = 0;
    localparam int OFF_CNT  = 4;
    localparam int OFF_STAT = 8;

    typedef enum logic [1:0] {
        SZ_8   = 2'b00,
        SZ_16  = 2'b01,
        SZ_32  = 2'b10,
        SZ_RSV = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdt_access.sv
module wdt_access
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [CTL_W-1:0]  ctl_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  live_q,
    output logic              ctl_we,
    output logic              cnt_we,
    output logic              stat_we,
    output logic              half_wr,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_err
);

    logic             size_ok;
    logic             hit_ctl, hit_cnt, hit_stat;
    logic             wide_ctl_rd;
    logic             err_d;
    logic [CNT_W-1:0] rd_mux;

    always_comb begin
        size_ok     = (bus_size == SZ_16) || (bus_size == SZ_32);
        hit_ctl     = (bus_addr == ADDR_W'(OFF_CTL));
        hit_cnt     = (bus_addr == ADDR_W'(OFF_CNT));
        hit_stat    = (bus_addr == ADDR_W'(OFF_STAT));
        wide_ctl_rd = bus_rd && hit_ctl && (bus_size == SZ_32);
        err_d       = ((bus_wr || bus_rd) && !size_ok) || (size_ok && wide_ctl_rd);
        ctl_we      = bus_wr && size_ok && hit_ctl;
        cnt_we      = bus_wr && size_ok && hit_cnt;
        stat_we     = bus_wr && size_ok && hit_stat;
        half_wr     = (bus_size == SZ_16);
        if (hit_ctl)       rd_mux = CNT_W'(ctl_q);
        else if (hit_cnt)  rd_mux = cnt_q;
        else if (hit_stat) rd_mux = live_q;
        else               rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_err   <= err_d;
            bus_rdata <= (bus_rd && !err_d) ? rd_mux : '0;
        end
    end

    // R2: a bad size code is reported in the following cycle
    a_r2_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && (bus_size == SZ_8 || bus_size == SZ_RSV)) |=> (bus_err && bus_rdata == '0));

    // R3: a word-sized read of control is refused
    a_r3_wide_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_CTL) && bus_size == SZ_32) |=> (bus_err && bus_rdata == '0));

    // R2: no register write strobe without an accepted size
    a_r2_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !size_ok |-> !(ctl_we || cnt_we || stat_we));

endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             expire,
    output logic [CTL_W-1:0] ctl_q,
    output logic             enabled,
    output logic [SEL_W-1:0] sel
);

    logic [CTL_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we) begin
            ctl_d           = wdata;
            ctl_d[ROLL_BIT] = ctl_q[ROLL_BIT] & ~wdata[ROLL_BIT];
        end
        if (expire) ctl_d[ROLL_BIT] = 1'b1;
        enabled = (ctl_q[EN_LSB +: EN_W] != EN_STOP);
        sel     = ctl_q[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    // R9: expiry leaves the rollover flag set
    a_r9_roll_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctl_q[ROLL_BIT]);

    // R11: flag only drops through a write of one
    a_r11_roll_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_we && wdata[ROLL_BIT])) |=> (ctl_q[ROLL_BIT] || !$past(ctl_q[ROLL_BIT])));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enabled,
    input  logic [SEL_W-1:0]   sel,
    input  logic               cnt_we,
    input  logic               stat_we,
    input  logic               half_wr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CNT_W-1:0]   live_q,
    output logic               expire,
    output logic [NUM_EVT-1:0] evt_o
);

    wd_state_e        state_q, state_d;
    wd_state_e        run_target;
    logic [CNT_W-1:0] cnt_new;
    logic             fire;

    always_comb begin
        expire  = enabled && !stat_we && (live_q == '0);
        cnt_new = half_wr ? {cnt_q[CNT_W-1:HALF_W], wdata[HALF_W-1:0]} : wdata;
        run_target = expire ? ST_FIRE : ST_RUN;
        unique case (state_q)
            ST_IDLE: state_d = enabled ? run_target : ST_IDLE;
            ST_RUN:  state_d = enabled ? run_target : ST_IDLE;
            ST_FIRE: state_d = enabled ? run_target : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            live_q <= '0;
        end else if (!enabled) begin
            if (cnt_we) begin
                cnt_q  <= cnt_new;
                live_q <= cnt_new;
            end
        end else if (stat_we || live_q == '0) begin
            live_q <= cnt_q;
        end else begin
            live_q <= live_q - CNT_W'(1);
        end
    end

    always_comb begin
        fire = (state_q == ST_FIRE);
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        assign evt_o[i] = fire && (sel == SEL_W'(i));
    end

    // R10: never more than one event pin
    a_r10_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o));

    // R10: pulse lasts a single clock for a non-zero reload
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt_o) && live_q != '0) |=> !(|evt_o));

    // R6: reload value frozen while running
    a_r6_cnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> $stable(cnt_q));

    // R7: service write reloads the live count
    a_r7_service: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && stat_we) |=> (live_q == $past(cnt_q)));

    // R8: one step down per running clock
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !stat_we && live_q != '0) |=> (live_q == $past(live_q) - CNT_W'(1)));

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_err,
    output logic              wd_reset,
    output logic              wd_nmi,
    output logic              wd_gpi
);

    logic               ctl_we, cnt_we, stat_we, half_wr;
    logic [CTL_W-1:0]   ctl_q;
    logic [CNT_W-1:0]   cnt_q, live_q;
    logic               enabled, expire;
    logic [SEL_W-1:0]   sel;
    logic [NUM_EVT-1:0] evt;

    wdt_access #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_size  (bus_size),
        .ctl_q     (ctl_q),
        .cnt_q     (cnt_q),
        .live_q    (live_q),
        .ctl_we    (ctl_we),
        .cnt_we    (cnt_we),
        .stat_we   (stat_we),
        .half_wr   (half_wr),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    wdt_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (ctl_we),
        .wdata   (bus_wdata[CTL_W-1:0]),
        .expire  (expire),
        .ctl_q   (ctl_q),
        .enabled (enabled),
        .sel     (sel)
    );

    wdt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (enabled),
        .sel     (sel),
        .cnt_we  (cnt_we),
        .stat_we (stat_we),
        .half_wr (half_wr),
        .wdata   (bus_wdata),
        .cnt_q   (cnt_q),
        .live_q  (live_q),
        .expire  (expire),
        .evt_o   (evt)
    );

    assign wd_reset = evt[0];
    assign wd_nmi   = evt[1];
    assign wd_gpi   = evt[2];

    // R1: nothing fires while stopped
    a_r1_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> !(wd_reset || wd_nmi || wd_gpi));

endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_err, wd_reset, wd_nmi, wd_gpi;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    wdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .wd_reset(wd_reset), .wd_nmi(wd_nmi), .wd_gpi(wd_gpi)
    );

    function automatic logic [2:0] evts();
        return {wd_gpi, wd_nmi, wd_reset};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic rd, input logic [1:0] sz,
                          input logic [3:0] a, input logic [31:0] d,
                          output logic [31:0] rdat, output logic e);
        bus_wr = wr; bus_rd = rd; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        rdat = bus_rdata;
        e = bus_err;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d,
                      output logic e);
        logic [31:0] unused_r;
        access(1'b1, 1'b0, sz, a, d, unused_r, e);
    endtask

    task automatic rd(input logic [1:0] sz, input logic [3:0] a,
                      output logic [31:0] r, output logic e);
        access(1'b0, 1'b1, sz, a, 32'h0, r, e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        e;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_size = 2'b10;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 evt", {29'd0, evts()}, 32'h0);
        chk("R1 err", {31'd0, bus_err}, 32'h0);
        rd(2'b01, 4'h0, r, e); chk("R1 ctl", r, 32'h0000_0AD0);
        rd(2'b10, 4'h4, r, e); chk("R1 cnt", r, 32'h0);
        rd(2'b10, 4'h8, r, e); chk("R1 stat", r, 32'h0);

        // R5 preload while stopped
        wr(2'b10, 4'h4, 32'h1234_5678, e);
        chk("R5 err", {31'd0, e}, 32'h0);

        // R2 R3 R4: sweep every size against every offset
        for (int sz = 0; sz < 4; sz++) begin
            for (int ai = 0; ai < 4; ai++) begin
                logic        xe;
                logic [31:0] xd;
                string       tag;
                xe = (sz == 0 || sz == 3) || (ai == 0 && sz == 2);
                if (xe)           xd = 32'h0;
                else if (ai == 0) xd = 32'h0000_0AD0;
                else if (ai == 3) xd = 32'h0;
                else              xd = 32'h1234_5678;
                if (sz == 0 || sz == 3)       tag = "R2";
                else if (ai == 0 && sz == 2)  tag = "R3";
                else if (ai == 3)             tag = "R4";
                else                          tag = "R5";
                rd(2'(sz), 4'(ai * 4), r, e);
                chk({tag, " rd err"}, {31'd0, e}, {31'd0, xe});
                chk({tag, " rd data"}, r, xd);
            end
        end

        // R2 bad-size writes are flagged and ignored
        wr(2'b00, 4'h4, 32'hDEAD_BEEF, e); chk("R2 wr8 err", {31'd0, e}, 32'h1);
        wr(2'b11, 4'h4, 32'hDEAD_BEEF, e); chk("R2 wr11 err", {31'd0, e}, 32'h1);
        wr(2'b11, 4'hC, 32'hDEAD_BEEF, e); chk("R2 unmapped priority", {31'd0, e}, 32'h1);
        rd(2'b10, 4'h4, r, e); chk("R2 cnt kept", r, 32'h1234_5678);

        // R4 unmapped write has no effect
        wr(2'b10, 4'hC, 32'h0000_0003, e); chk("R4 wr err", {31'd0, e}, 32'h0);
        rd(2'b01, 4'h0, r, e); chk("R4 ctl kept", r, 32'h0000_0AD0);
        rd(2'b10, 4'h8, r, e); chk("R4 stat kept", r, 32'h1234_5678);

        // R5 halfword write keeps the upper half
        wr(2'b01, 4'h4, 32'hAAAA_5555, e);
        rd(2'b10, 4'h4, r, e); chk("R5 half cnt", r, 32'h1234_5555);
        rd(2'b10, 4'h8, r, e); chk("R5 half stat", r, 32'h1234_5555);

        // R7 status write ignored while stopped
        wr(2'b10, 4'h8, 32'h0, e);
        rd(2'b10, 4'h8, r, e); chk("R7 stopped stat", r, 32'h1234_5555);

        // R8 decrement: 10 idle clocks plus start and stop edges
        wr(2'b10, 4'h4, 32'd100, e);
        wr(2'b01, 4'h0, 32'h0000_0003, e);
        repeat (10) @(negedge clk);
        chk("R10 none selected", {29'd0, evts()}, 32'h0);
        wr(2'b01, 4'h0, 32'h0000_0AD3, e);
        rd(2'b10, 4'h8, r, e); chk("R8 decrement", r, 32'd89);

        // R6 reload write discarded while running
        wr(2'b01, 4'h0, 32'h0000_0003, e);
        wr(2'b10, 4'h4, 32'd999, e);
        wr(2'b01, 4'h0, 32'h0000_0AD3, e);
        rd(2'b10, 4'h4, r, e); chk("R6 cnt locked", r, 32'd100);

        // R7 service while running, enable field 0x01
        wr(2'b10, 4'h4, 32'd200, e);
        wr(2'b01, 4'h0, 32'h0000_0013, e);
        repeat (5) @(negedge clk);
        wr(2'b10, 4'h8, 32'h0000_1234, e);
        wr(2'b01, 4'h0, 32'h0000_0AD3, e);
        rd(2'b10, 4'h8, r, e); chk("R7 service", r, 32'd199);

        // R9 R10 R11: every selection across short reloads
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= 5; n++) begin
                logic [2:0] early;
                logic [2:0] xev;
                early = 3'b000;
                xev = (s == 3) ? 3'b000 : 3'(1 << s);
                wr(2'b01, 4'h0, 32'h0000_8AD0 | 32'(s), e);
                wr(2'b10, 4'h4, 32'(n), e);
                wr(2'b01, 4'h0, 32'(s), e);
                for (int k = 1; k <= n; k++) begin
                    @(negedge clk);
                    early |= evts();
                end
                chk("R9 no early pulse", {29'd0, early}, 32'h0);
                @(negedge clk);
                chk("R10 pulse pin", {29'd0, evts()}, {29'd0, xev});
                @(negedge clk);
                chk("R10 single cycle", {29'd0, evts()}, 32'h0);
                wr(2'b01, 4'h0, 32'h0000_0AD0 | 32'(s), e);
                rd(2'b01, 4'h0, r, e);
                chk("R9 R11 roll set and kept", r, 32'h0000_8AD0 | 32'(s));
                wr(2'b01, 4'h0, 32'h0000_8AD0 | 32'(s), e);
                rd(2'b01, 4'h0, r, e);
                chk("R11 roll cleared", r, 32'h0000_0AD0 | 32'(s));
            end
        end

        // R11 other control bits written directly
        wr(2'b10, 4'h0, 32'h0000_7AD5, e);
        rd(2'b01, 4'h0, r, e); chk("R11 plain bits", r, 32'h0000_7AD5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule